// File: doc/BRIEF.md
# Page and Synchronous Burst Sequencer

This block turns one external bus cycle into a multi-beat page or synchronous burst transfer. When a requester pulses `start`, the block latches the direction, the length code, the timing settings and the mode. It then asserts the chip select and the address-latch strobe and performs a first access with ordinary asynchronous wait-state timing. After that first access it produces one further data beat per bus clock, plus any configured burst wait states. The run ends after a fixed beat count or, in continuous synchronous mode, after the requester asks it to stop.

The block runs on a clock at twice the bus-clock rate, so that half-bus-clock edges can be placed exactly. One period of `clk` is one *tick*. Tick 0 is the first tick in which `cs_n` is low. `bclk` is the bus clock toward the memory. It runs only in synchronous mode, is high during odd ticks and is otherwise held low. `beat_valid` is high for one tick at the end of each data beat. The requester moves one halfword per pulse: it captures read data or supplies the next write datum.

All strobes are active low. `adv_n` is the address-latch strobe and `we_n` is the write enable.

Top module: `pgb_sequencer`

## Requirements
- R1: Length code 00 gives 4 beats, 01 gives 8 beats and 10 gives 16 beats. In asynchronous mode, code 11 is treated as 16 beats.
- R2: The first beat's `beat_valid` comes at tick 2·F−1, where F is `first_len` in bus clocks and 0 is treated as 1. `rd_n` of a read falls at tick 2·`oe_delay`. `we_n` of an asynchronous write falls at tick 2·`oe_delay`+1. These rules assume `oe_delay` < F.
- R3: Each beat after the first ends 2·(1+W) ticks after the previous one, where W is `burst_wait`.
- R4: `cs_n` and the active strobe stay low without a gap until the final beat. All of them go high in the tick after the final `beat_valid`.
- R5: `rd_n` and `we_n` are never low together. A synchronous read never lowers `we_n`. A synchronous write holds `we_n` low from tick 0, whatever `oe_delay` is.
- R6: `adv_n` is low from tick 0 for a set number of ticks. In asynchronous mode this is 2 ticks, or 4 ticks with `long_latch`. In synchronous mode it is 2 ticks, or 3 ticks with `long_latch`.
- R7: In synchronous mode `bclk` is high exactly in the odd ticks of the transfer, so its first rising edge falls at tick 1 while `adv_n` is low. In asynchronous mode and when idle, `bclk` stays low.
- R8: Synchronous mode with code 11 is continuous. If `stop` is high at the end of tick k, the last beat is the first beat that ends at a tick greater than k.
- R9: `start` has no effect while a transfer is in progress.
- R10: After reset, `cs_n`, `rd_n`, `we_n` and `adv_n` are high, and `bclk` and `beat_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| write | input | 1 | 1 = write transfer, 0 = read |
| len_code | input | 2 | Beat count code (see R1, R8) |
| sync_mode | input | 1 | 1 = synchronous burst, 0 = asynchronous page |
| long_latch | input | 1 | Selects the long address-latch strobe |
| burst_wait | input | WW | Extra bus clocks per later beat |
| oe_delay | input | DW | Strobe assert delay in bus clocks |
| first_len | input | FW | First-access length in bus clocks |
| stop | input | 1 | End request for continuous mode |
| cs_n | output | 1 | Chip select |
| rd_n | output | 1 | Read strobe |
| we_n | output | 1 | Write enable |
| adv_n | output | 1 | Address-latch strobe |
| bclk | output | 1 | Gated bus clock toward the memory |
| beat_valid | output | 1 | One-tick pulse per data beat |

## Verification
The in-line properties watch several rules on every cycle. They check that the chip select is held unbroken until the final beat, that every line is released together right after that beat, and that beat pulses are never back to back. They also check that read and write strobes never overlap, that `bclk` stays quiet in asynchronous or idle operation, and that the address strobe is low at the first synchronous clock edge. Exact beat placement under different wait settings needs the bench's scenarios, as do the strobe-fall ticks, the latch widths, the length decoding, the stop timing in continuous mode and the rejection of a second start.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

  typedef enum logic [1:0] {
    LEN_4    = 2'b00,
    LEN_8    = 2'b01,
    LEN_16   = 2'b10,
    LEN_CONT = 2'b11
  } len_code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic       wr;
    logic       sync;
    logic       long_adv;
    logic       cont;
    logic [4:0] total;
  } burst_cfg_t;

  // beat count for a length code; code 11 maps to 16 when not continuous
  function automatic logic [4:0] beat_total(input logic [1:0] code);
    case (len_code_e'(code))
      LEN_4:   beat_total = 5'd4;
      LEN_8:   beat_total = 5'd8;
      default: beat_total = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pgb_beat_timer.sv
module pgb_beat_timer #(
  parameter int FW = 4,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          run,
  input  logic [FW-1:0] first_len,
  input  logic [WW-1:0] wait_st,
  input  logic          cont,
  input  logic [4:0]    total,
  input  logic          stop,
  output logic          beat_done,
  output logic          last_beat
);

  localparam int CW = ((FW > WW + 1) ? FW : WW + 1) + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] first_load, next_load;
  logic [4:0]    idx_q, idx_d;
  logic          stop_q, stop_d;
  logic          upd;

  always_comb begin
    first_load = (first_len == '0) ? CW'(1) : (CW'({first_len, 1'b0}) - CW'(1));
    next_load  = CW'({wait_st, 1'b0}) + CW'(1);
  end

  assign beat_done = run && (cnt_q == '0);
  assign last_beat = cont ? stop_q : (idx_q == (total - 5'd1));

  always_comb begin
    upd    = launch | run;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    stop_d = stop_q;
    if (launch) begin
      cnt_d  = first_load;
      idx_d  = '0;
      stop_d = 1'b0;
    end else if (run) begin
      stop_d = stop_q | stop;
      if (beat_done) begin
        cnt_d = next_load;
        idx_d = idx_q + 5'd1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      stop_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      stop_q <= stop_d;
    end
  end

  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> !beat_done); // R3

endmodule

// File: rtl/pgb_strobe_gen.sv
module pgb_strobe_gen #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          run,
  input  logic          wr,
  input  logic          sync,
  input  logic          long_adv,
  input  logic [DW-1:0] oe_dly,
  output logic          adv_n,
  output logic          rd_n,
  output logic          we_n,
  output logic          bclk
);

  localparam int TW = DW + 2;

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          ph_q, ph_d;
  logic [TW-1:0] adv_len, rd_at, we_at;
  logic          upd;

  always_comb begin
    upd    = launch | run;
    tcnt_d = tcnt_q;
    ph_d   = ph_q;
    if (launch) begin
      tcnt_d = '0;
      ph_d   = 1'b0;
    end else if (run) begin
      ph_d = ~ph_q;
      if (tcnt_q != '1) tcnt_d = tcnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      ph_q   <= 1'b0;
    end else if (upd) begin
      tcnt_q <= tcnt_d;
      ph_q   <= ph_d;
    end
  end

  always_comb begin
    if (sync) adv_len = long_adv ? TW'(3) : TW'(2);
    else      adv_len = long_adv ? TW'(4) : TW'(2);
    rd_at = TW'({oe_dly, 1'b0});
    we_at = sync ? '0 : TW'({oe_dly, 1'b1});
  end

  assign adv_n = ~(run && (tcnt_q < adv_len));
  assign rd_n  = ~(run && !wr && (tcnt_q >= rd_at));
  assign we_n  = ~(run && wr && (tcnt_q >= we_at));
  assign bclk  = run && sync && ph_q;

  AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> we_n); // R5

  AST_SYNC_ADV_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync && tcnt_q == TW'(1)) |-> (!adv_n && bclk)); // R7

endmodule

// File: rtl/pgb_sequencer.sv
module pgb_sequencer
  import pgb_pkg::*;
#(
  parameter int FW = 4,
  parameter int DW = 4,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          write,
  input  logic [1:0]    len_code,
  input  logic          sync_mode,
  input  logic          long_latch,
  input  logic [WW-1:0] burst_wait,
  input  logic [DW-1:0] oe_delay,
  input  logic [FW-1:0] first_len,
  input  logic          stop,
  output logic          cs_n,
  output logic          rd_n,
  output logic          we_n,
  output logic          adv_n,
  output logic          bclk,
  output logic          beat_valid
);

  seq_state_e    state_q, state_d;
  burst_cfg_t    cfg_q, cfg_d;
  logic [DW-1:0] oe_q;
  logic [WW-1:0] wait_q;
  logic          launch, run, beat_done, last_beat;

  assign run    = (state_q == ST_RUN);
  assign launch = (state_q == ST_IDLE) && start;

  always_comb begin
    cfg_d.wr       = write;
    cfg_d.sync     = sync_mode;
    cfg_d.long_adv = long_latch;
    cfg_d.cont     = sync_mode && (len_code == LEN_CONT);
    cfg_d.total    = beat_total(len_code);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (beat_done && last_beat) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      oe_q   <= '0;
      wait_q <= '0;
    end else if (launch) begin
      cfg_q  <= cfg_d;
      oe_q   <= oe_delay;
      wait_q <= burst_wait;
    end
  end

  pgb_beat_timer #(.FW(FW), .WW(WW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .run       (run),
    .first_len (first_len),
    .wait_st   (wait_q),
    .cont      (cfg_q.cont),
    .total     (cfg_q.total),
    .stop      (stop),
    .beat_done (beat_done),
    .last_beat (last_beat)
  );

  pgb_strobe_gen #(.DW(DW)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .run      (run),
    .wr       (cfg_q.wr),
    .sync     (cfg_q.sync),
    .long_adv (cfg_q.long_adv),
    .oe_dly   (oe_q),
    .adv_n    (adv_n),
    .rd_n     (rd_n),
    .we_n     (we_n),
    .bclk     (bclk)
  );

  assign cs_n       = ~run;
  assign beat_valid = beat_done;

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !(beat_valid && last_beat)) |=> !cs_n); // R4

  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && last_beat) |=> (cs_n && rd_n && we_n && adv_n)); // R4

  AST_BCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cfg_q.sync) |-> !bclk); // R7

endmodule

// File: tb/sim_pgb_sequencer.sv
module sim_pgb_sequencer;

  localparam int FW = 4;
  localparam int DW = 4;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start, write, sync_mode, long_latch, stop;
  logic [1:0]    len_code;
  logic [WW-1:0] burst_wait;
  logic [DW-1:0] oe_delay;
  logic [FW-1:0] first_len;
  logic cs_n, rd_n, we_n, adv_n, bclk, beat_valid;

  always #2 clk = ~clk;

  pgb_sequencer #(.FW(FW), .DW(DW), .WW(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .len_code(len_code),
    .sync_mode(sync_mode), .long_latch(long_latch), .burst_wait(burst_wait),
    .oe_delay(oe_delay), .first_len(first_len), .stop(stop),
    .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .adv_n(adv_n), .bclk(bclk),
    .beat_valid(beat_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string cur_req = "R3";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: measures each transfer and pops expected beat ticks
  bit in_tx = 0;
  int t, adv_cnt, rd_fall, we_fall, bclk_cnt, cs_len, idle_noise;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (!in_tx) begin
          in_tx = 1; t = 0; adv_cnt = 0; rd_fall = -1; we_fall = -1;
          bclk_cnt = 0;
        end else t++;
        if (!adv_n) adv_cnt++;
        if (!rd_n && rd_fall < 0) rd_fall = t;
        if (!we_n && we_fall < 0) we_fall = t;
        if (bclk) bclk_cnt++;
        if (beat_valid) begin
          if (exp_q.size() == 0) chk(0, cur_req, t, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(t == e, cur_req, t, e);
          end
        end
        cs_len = t + 1;
      end else begin
        in_tx = 0;
        if (bclk || beat_valid || !rd_n || !we_n || !adv_n) idle_noise++;
      end
    end
  end

  task automatic run_burst(input string req, input bit wr, input bit sy, input bit lng,
                           input int code, input int w, input int dly, input int f,
                           input int stopk, input bit poke);
    int fe, n, clen, adv_e, rd_e, we_e, bc_e;
    fe = (f == 0) ? 1 : f;
    if (sy && code == 3) begin
      n = 1;
      while ((2*fe - 1 + (n-1)*2*(1+w)) < stopk + 1) n++;
    end else n = (code == 0) ? 4 : (code == 1) ? 8 : 16;
    for (int i = 0; i < n; i++) exp_q.push_back(2*fe - 1 + i*2*(1+w));
    clen  = 2*fe + (n-1)*2*(1+w);
    adv_e = sy ? (lng ? 3 : 2) : (lng ? 4 : 2);
    if (adv_e > clen) adv_e = clen;
    rd_e  = wr ? -1 : 2*dly;
    we_e  = !wr ? -1 : (sy ? 0 : 2*dly + 1);
    bc_e  = sy ? clen/2 : 0;
    cur_req = req;
    idle_noise = 0;
    @(negedge clk);
    write = wr; sync_mode = sy; long_latch = lng; len_code = code[1:0];
    burst_wait = w[WW-1:0]; oe_delay = dly[DW-1:0]; first_len = f[FW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      if (stopk >= 0) begin
        repeat (stopk) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
      end
      if (poke) begin
        repeat (2) @(negedge clk);
        start = 1'b1; write = ~wr; len_code = 2'b00;
        @(negedge clk);
        start = 1'b0;
      end
    join
    while (!cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cs_len == clen, {req, " cs length"}, cs_len, clen);
    chk(exp_q.size() == 0, {req, " missing beats"}, exp_q.size(), 0);
    chk(adv_cnt == adv_e, "R6 adv width", adv_cnt, adv_e);
    chk(rd_fall == rd_e, "R2 rd fall", rd_fall, rd_e);
    chk(we_fall == we_e, "R5 we fall", we_fall, we_e);
    chk(bclk_cnt == bc_e, "R7 bclk high ticks", bclk_cnt, bc_e);
    chk(idle_noise == 0, "R4 idle after end", idle_noise, 0);
    exp_q.delete();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 0; write = 0; sync_mode = 0; long_latch = 0; stop = 0;
    len_code = 0; burst_wait = 0; oe_delay = 0; first_len = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n && rd_n && we_n && adv_n, "R10 strobes high", {cs_n, rd_n, we_n, adv_n}, 15);
    chk(!bclk && !beat_valid, "R10 bclk/beat low", {bclk, beat_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2 R3 R4 R9: async read, 4 beats, second start ignored
    run_burst("R9 R1 4-beat", 0, 0, 0, 0, 0, 2, 3, -1, 1);
    // R1 R2 R6: async write, 8 beats, wait 1, long latch
    run_burst("R1 8-beat", 1, 0, 1, 1, 1, 1, 3, -1, 0);
    // R1 R3: async read, 16 beats, wait 2
    run_burst("R3 16-beat", 0, 0, 0, 2, 2, 0, 2, -1, 0);
    // R1: code 11 in async mode acts as 16
    run_burst("R1 code11 async", 0, 0, 0, 3, 0, 1, 2, -1, 0);
    // R2: first_len 0 treated as 1
    run_burst("R2 first zero", 0, 0, 0, 0, 0, 0, 0, -1, 0);
    // R5 R6 R7: sync read, long latch
    run_burst("R7 sync read", 0, 1, 1, 0, 0, 1, 2, -1, 0);
    // R5: sync write ignores oe_delay
    run_burst("R5 sync write", 1, 1, 0, 1, 0, 3, 4, -1, 0);
    // R8: continuous, stop at tick 8 and at tick 9
    run_burst("R8 stop k8", 0, 1, 0, 3, 0, 0, 2, 8, 0);
    run_burst("R8 stop k9", 1, 1, 0, 3, 0, 0, 2, 9, 0);
    run_burst("R8 stop wait", 0, 1, 1, 3, 1, 1, 3, 12, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule